// File: doc/BRIEF.md
# Way-Predicted Two-Way Instruction Cache Lookup

This block is the lookup side of a read-only, two-way set-associative instruction cache. Each set holds a prediction bit that names the way to probe first. Only that one way is compared on the cycle a request is accepted. A correct guess returns the addressed word one cycle after acceptance. A wrong guess spends two more cycles probing the other way, and the response then arrives three cycles after acceptance. When the second probe hits, the prediction bit is turned to the way that hit.

When neither way holds the line, the block reports a miss and waits for the line on its refill port. The whole line is written into the least recently used way of the set, and the prediction bit then points at that way. The requester accepts the miss response and issues the request again. One access is in flight at a time: the request port is ready only while the unit is idle. Four counters record accepted accesses, first-probe hits, second-probe hits and misses, so prediction accuracy can be measured from outside.

The defaults are 32-bit byte addresses, 64-byte lines, 128 sets and 32-bit words. Address bits [5:2] select the word, bits [12:6] the set and bits [31:13] the tag.

Top module: `wpc_icache`

## Requirements
- R1: After reset, req_ready_o is 1, resp_valid_o is 0, all four counters read 0 and every line is invalid, so the first access to any address misses.
- R2: A request is taken on a rising edge where req_valid_i and req_ready_o are both 1. req_ready_o is 0 from the edge that takes a request which is not a first-probe hit until the unit is idle again.
- R3: When the predicted way holds the line, resp_valid_o and resp_hit_o are 1 in the cycle that follows the accepting edge, and req_ready_o stays 1.
- R4: When only the other way holds the line, resp_valid_o and resp_hit_o are 1 three cycles after the accepting edge, with the correct word.
- R5: After a second-probe hit, the set's prediction bit names the way that hit, so the next access to that line is a first-probe hit.
- R6: When neither way holds the line, resp_valid_o is 1 with resp_hit_o 0 three cycles after acceptance. req_ready_o then stays 0 until a cycle with refill_valid_i at 1.
- R7: A refill writes into the set's least recently used way. A first-probe hit, a second-probe hit or a refill makes the way it used the most recently used one.
- R8: resp_data_o is the 32-bit word at address bits [5:2] of the line. On refill_line_i, word w sits at bits [32*w+31 : 32*w].
- R9: stat_access_o counts accepted requests. stat_fast_o, stat_slow_o and stat_miss_o count first-probe hits, second-probe hits and misses, each at the edge its response is registered.
- R10: refill_valid_i is ignored unless the unit is waiting for a refill: no line is written and no response is produced.
- R11: After reset every prediction bit and replacement bit names way 0. A refill sets the set's prediction bit to the way it filled, so after two cold misses to one set the first line sits in way 0 and is reached only by a second probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 32 | Byte address of the requested word |
| req_ready_o | output | 1 | Unit idle and able to take a request |
| resp_valid_o | output | 1 | Response present for one cycle |
| resp_data_o | output | 32 | Requested word, zero on a miss |
| resp_hit_o | output | 1 | 1 for a hit, 0 for a miss |
| refill_valid_i | input | 1 | Line on refill_line_i is to be written |
| refill_line_i | input | 512 | Full line data for the missed address |
| stat_access_o | output | 32 | Accepted request count |
| stat_fast_o | output | 32 | First-probe hit count |
| stat_slow_o | output | 32 | Second-probe hit count |
| stat_miss_o | output | 32 | Miss count |

## Verification
The assertions assume that a refill belongs to the miss that is waiting for it and carries that address's line. They also assume that reset is applied before the first request, and that the two ways never hold the same tag in one set, which holds only if lines enter through refills after misses. The stimulus drives refill_valid_i only after the miss response has been seen. The one exception is a single deliberate pulse while idle, used to show that such a pulse is ignored. Every refill line is built from a fixed function of its address, so any word returned by a hit can be predicted from the address alone.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int WAYS  = 2;
  localparam int WAY_W = 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_PROBE2 = 2'd2,
    ST_FILL   = 2'd3
  } wpc_state_e;
endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store import wpc_pkg::*; #(
  parameter int SETS  = 128,
  parameter int TAG_W = 19,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic [WAYS-1:0]  hit_o,
  input  logic             wr_en_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_mem [SETS];
    logic             wr_sel;

    assign wr_sel = wr_en_i && (wr_way_i == WAY_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     vld_q <= '0;
      else if (wr_sel) vld_q[wr_idx_i] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (wr_sel) tag_mem[wr_idx_i] <= wr_tag_i;
    end

    assign hit_o[w] = vld_q[rd_idx_i] && (tag_mem[rd_idx_i] == rd_tag_i);
  end
endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store import wpc_pkg::*; #(
  parameter int SETS   = 128,
  parameter int LINE_W = 512,
  parameter int WORD_W = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WPL    = LINE_W / WORD_W,
  localparam int WSEL_W = $clog2(WPL)
) (
  input  logic              clk_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WSEL_W-1:0] rd_wsel_i,
  output logic [WORD_W-1:0] rd_word_o,
  input  logic              wr_en_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LINE_W-1:0] wr_line_i
);
  logic [WAYS-1:0][LINE_W-1:0] rd_line;
  logic [LINE_W-1:0]           sel_line;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LINE_W-1:0] line_mem [SETS];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_way_i == WAY_W'(w))) line_mem[wr_idx_i] <= wr_line_i;
    end

    assign rd_line[w] = line_mem[rd_idx_i];
  end

  assign sel_line  = rd_line[rd_way_i];
  assign rd_word_o = sel_line[rd_wsel_i*WORD_W +: WORD_W];
endmodule

// File: rtl/wpc_way_ctrl.sv
module wpc_way_ctrl #(
  parameter int SETS = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic             pred_o,
  output logic             lru_o,
  input  logic             upd_en_i,
  input  logic             set_pred_i,
  input  logic             pred_val_i,
  input  logic             lru_val_i
);
  // per set: way guessed first, way to replace next
  logic [SETS-1:0] pred_bits, lru_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_bits <= '0;
      lru_bits  <= '0;
    end else if (upd_en_i) begin
      lru_bits[idx_i] <= lru_val_i;
      if (set_pred_i) pred_bits[idx_i] <= pred_val_i;
    end
  end

  assign pred_o = pred_bits[idx_i];
  assign lru_o  = lru_bits[idx_i];
endmodule

// File: rtl/wpc_stats.sv
module wpc_stats #(
  parameter int NCNT  = 4,
  parameter int CNT_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NCNT-1:0]            inc_i,
  output logic [NCNT-1:0][CNT_W-1:0] cnt_o
);
  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (inc_i[c]) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o[c] = cnt_q;
  end
endmodule

// File: rtl/wpc_icache.sv
module wpc_icache import wpc_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 128,
  parameter int WORD_W     = 32,
  parameter int CNT_W      = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  output logic                    req_ready_o,
  output logic                    resp_valid_o,
  output logic [WORD_W-1:0]       resp_data_o,
  output logic                    resp_hit_o,
  input  logic                    refill_valid_i,
  input  logic [LINE_BYTES*8-1:0] refill_line_i,
  output logic [CNT_W-1:0]        stat_access_o,
  output logic [CNT_W-1:0]        stat_fast_o,
  output logic [CNT_W-1:0]        stat_slow_o,
  output logic [CNT_W-1:0]        stat_miss_o
);
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int WB_W       = $clog2(WORD_BYTES);
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int WSEL_W     = OFF_W - WB_W;
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;

  wpc_state_e        state_q, state_d;
  logic [TAG_W-1:0]  in_tag, tag_q, lk_tag;
  logic [IDX_W-1:0]  in_idx, idx_q, lk_idx;
  logic [WSEL_W-1:0] in_wsel, wsel_q, lk_wsel;
  logic              pred_q, pred_rd, lru_rd, probe_way;
  logic [WAYS-1:0]   hit_vec;
  logic              idle, fire, fast_hit, slow_hit, miss_now, fill_now;
  logic              upd_en, set_pred, pred_val, lru_val;
  logic [WORD_W-1:0] rd_word;
  logic              resp_valid_q, resp_hit_q;
  logic [WORD_W-1:0] resp_data_q;
  logic [3:0][CNT_W-1:0] cnt;
  logic              unused_lo;

  assign in_tag    = req_addr_i[ADDR_W-1 -: TAG_W];
  assign in_idx    = req_addr_i[OFF_W +: IDX_W];
  assign in_wsel   = req_addr_i[WB_W +: WSEL_W];
  assign unused_lo = ^req_addr_i[WB_W-1:0];

  assign idle        = (state_q == ST_IDLE);
  assign req_ready_o = idle;
  assign fire        = req_valid_i && idle;

  // idle: look up the incoming request; otherwise the held one
  assign lk_tag    = idle ? in_tag  : tag_q;
  assign lk_idx    = idle ? in_idx  : idx_q;
  assign lk_wsel   = idle ? in_wsel : wsel_q;
  assign probe_way = idle ? pred_rd : ~pred_q;

  assign fast_hit = fire && hit_vec[probe_way];
  assign slow_hit = (state_q == ST_PROBE2) && hit_vec[probe_way];
  assign miss_now = (state_q == ST_PROBE2) && !hit_vec[probe_way];
  assign fill_now = (state_q == ST_FILL) && refill_valid_i;

  wpc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (lk_idx),
    .rd_tag_i (lk_tag),
    .hit_o    (hit_vec),
    .wr_en_i  (fill_now),
    .wr_way_i (lru_rd),
    .wr_idx_i (idx_q),
    .wr_tag_i (tag_q)
  );

  wpc_data_store #(.SETS(SETS), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_data (
    .clk_i     (clk_i),
    .rd_way_i  (probe_way),
    .rd_idx_i  (lk_idx),
    .rd_wsel_i (lk_wsel),
    .rd_word_o (rd_word),
    .wr_en_i   (fill_now),
    .wr_way_i  (lru_rd),
    .wr_idx_i  (idx_q),
    .wr_line_i (refill_line_i)
  );

  wpc_way_ctrl #(.SETS(SETS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (lk_idx),
    .pred_o     (pred_rd),
    .lru_o      (lru_rd),
    .upd_en_i   (upd_en),
    .set_pred_i (set_pred),
    .pred_val_i (pred_val),
    .lru_val_i  (lru_val)
  );

  always_comb begin
    upd_en   = 1'b0;
    set_pred = 1'b0;
    pred_val = pred_q;
    lru_val  = 1'b0;
    if (fast_hit) begin
      upd_en  = 1'b1;
      lru_val = ~pred_rd;
    end else if (slow_hit) begin
      upd_en   = 1'b1;
      set_pred = 1'b1;
      pred_val = ~pred_q;
      lru_val  = pred_q;
    end else if (fill_now) begin
      upd_en   = 1'b1;
      set_pred = 1'b1;
      pred_val = lru_rd;
      lru_val  = ~lru_rd;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (fire && !fast_hit) state_d = ST_WAIT;
      ST_WAIT:   state_d = ST_PROBE2;
      ST_PROBE2: state_d = slow_hit ? ST_IDLE : ST_FILL;
      ST_FILL:   if (refill_valid_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      idx_q   <= '0;
      wsel_q  <= '0;
      pred_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (fire) begin
        tag_q  <= in_tag;
        idx_q  <= in_idx;
        wsel_q <= in_wsel;
        pred_q <= pred_rd;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      resp_valid_q <= fast_hit || (state_q == ST_PROBE2);
      resp_hit_q   <= fast_hit || slow_hit;
      resp_data_q  <= (fast_hit || slow_hit) ? rd_word : '0;
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_hit_o   = resp_hit_q;
  assign resp_data_o  = resp_data_q;

  wpc_stats #(.NCNT(4), .CNT_W(CNT_W)) u_stats (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  ({miss_now, slow_hit, fast_hit, fire}),
    .cnt_o  (cnt)
  );

  assign stat_access_o = cnt[0];
  assign stat_fast_o   = cnt[1];
  assign stat_slow_o   = cnt[2];
  assign stat_miss_o   = cnt[3];
endmodule

// File: rtl/wpc_icache_chk.sv
module wpc_icache_chk import wpc_pkg::*; #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input wpc_state_e       state_i,
  input logic             fast_hit_i,
  input logic             req_valid_i,
  input logic             req_ready_i,
  input logic             resp_valid_i,
  input logic             resp_hit_i,
  input logic             refill_valid_i,
  input logic [CNT_W-1:0] stat_access_i,
  input logic [CNT_W-1:0] stat_fast_i,
  input logic [CNT_W-1:0] stat_slow_i,
  input logic [CNT_W-1:0] stat_miss_i
);
  logic [CNT_W-1:0] done_sum;
  assign done_sum = stat_fast_i + stat_slow_i + stat_miss_i;

  // R1
  resp_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_i |-> ($past(fast_hit_i) || $past(state_i == ST_PROBE2)));

  // R2
  busy_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE) |-> !req_ready_i);

  // R3
  fast_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_i && fast_hit_i) |=> (resp_valid_i && resp_hit_i && req_ready_i));

  // R4
  slow_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_PROBE2) |=> resp_valid_i);

  // R6
  miss_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_i && !resp_hit_i) |-> (state_i == ST_FILL));

  // R6
  fill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FILL && !refill_valid_i) |=> (state_i == ST_FILL));

  // R9
  stat_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_access_i - done_sum) <= CNT_W'(1));
endmodule

bind wpc_icache wpc_icache_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .state_i        (state_q),
  .fast_hit_i     (fast_hit),
  .req_valid_i    (req_valid_i),
  .req_ready_i    (req_ready_o),
  .resp_valid_i   (resp_valid_o),
  .resp_hit_i     (resp_hit_o),
  .refill_valid_i (refill_valid_i),
  .stat_access_i  (stat_access_o),
  .stat_fast_i    (stat_fast_o),
  .stat_slow_i    (stat_slow_o),
  .stat_miss_i    (stat_miss_o)
);

// File: tb/tb_wpc_icache.sv
module tb_wpc_icache;
  localparam int SETS   = 128;
  localparam int LINE_W = 512;
  localparam int WPL    = 16;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               req_valid_i, req_ready_o;
  logic [31:0]        req_addr_i;
  logic               resp_valid_o, resp_hit_o;
  logic [31:0]        resp_data_o;
  logic               refill_valid_i;
  logic [LINE_W-1:0]  refill_line_i;
  logic [31:0]        stat_access_o, stat_fast_o, stat_slow_o, stat_miss_o;

  wpc_icache dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_ready_o(req_ready_o),
    .resp_valid_o(resp_valid_o), .resp_data_o(resp_data_o), .resp_hit_o(resp_hit_o),
    .refill_valid_i(refill_valid_i), .refill_line_i(refill_line_i),
    .stat_access_o(stat_access_o), .stat_fast_o(stat_fast_o),
    .stat_slow_o(stat_slow_o), .stat_miss_o(stat_miss_o)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic        hit;
    logic [31:0] data;
    string       lbl;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0;
  int n_acc = 0, n_fast = 0, n_slow = 0, n_miss = 0;

  logic        m_vld  [2][SETS];
  logic [18:0] m_tag  [2][SETS];
  logic        m_pred [SETS];
  logic        m_lru  [SETS];

  function automatic void chk(bit ok, string lbl, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", lbl, act, exp);
    end
  endfunction

  function automatic logic [31:0] mk(logic [18:0] tg, logic [6:0] ix, logic [3:0] wd);
    return {tg, ix, wd, 2'b00};
  endfunction

  function automatic logic [31:0] word_of(logic [31:0] a);
    logic [31:0] la;
    la = {a[31:2], 2'b00};
    return la ^ 32'hA5C3_0F19 ^ (la << 7);
  endfunction

  function automatic logic [LINE_W-1:0] line_of(logic [31:0] a);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < WPL; w++) l[w*32 +: 32] = word_of({a[31:6], 4'(w), 2'b00});
    return l;
  endfunction

  // monitor: pops expected responses as they appear
  always @(negedge clk) begin
    if (rst_ni) begin
      if (resp_valid_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected response", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cyc == e.due, {e.lbl, " latency"}, 64'(cyc), 64'(e.due));
          chk(resp_hit_o == e.hit, {e.lbl, " hit flag"}, 64'(resp_hit_o), 64'(e.hit));
          if (e.hit) chk(resp_data_o == e.data, {e.lbl, " R8 data word"}, 64'(resp_data_o), 64'(e.data));
        end
      end else if (exp_q.size() != 0 && exp_q[0].due < cyc) begin
        chk(1'b0, {exp_q[0].lbl, " missing response"}, 64'(cyc), 64'(exp_q[0].due));
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic access(input logic [31:0] a, input string lbl);
    int          idx, kind, acc;
    logic [18:0] tg;
    logic        pw, way;
    exp_t        e;
    idx = int'(a[12:6]);
    tg  = a[31:13];
    pw  = m_pred[idx];
    if (m_vld[pw][idx] && m_tag[pw][idx] == tg) kind = 0;
    else if (m_vld[~pw][idx] && m_tag[~pw][idx] == tg) kind = 1;
    else kind = 2;

    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    @(posedge clk);
    #1;
    acc = cyc;
    n_acc++;
    e.due  = (kind == 0) ? acc : acc + 2;
    e.hit  = (kind != 2);
    e.data = word_of(a);
    e.lbl  = {lbl, (kind == 0) ? " R3" : (kind == 1) ? " R4" : " R6"};
    exp_q.push_back(e);
    if (kind == 0) begin
      n_fast++;
      m_lru[idx] = ~pw;
    end else if (kind == 1) begin
      n_slow++;
      m_pred[idx] = ~pw;
      m_lru[idx]  = pw;
    end else n_miss++;

    @(negedge clk);
    req_valid_i = 1'b0;
    if (kind != 0) chk(req_ready_o == 1'b0, {lbl, " R2 busy after accept"}, 64'(req_ready_o), 0);
    if (kind == 2) begin
      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) begin
        @(negedge clk);
        chk(req_ready_o == 1'b0, {lbl, " R6 waits for refill"}, 64'(req_ready_o), 0);
      end
      refill_valid_i = 1'b1;
      refill_line_i  = line_of(a);
      @(negedge clk);
      refill_valid_i = 1'b0;
      way = m_lru[idx];
      m_vld[way][idx] = 1'b1;
      m_tag[way][idx] = tg;
      m_pred[idx]     = way;
      m_lru[idx]      = ~way;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: act=%0d cycles exp=completion", cyc);
    summary();
    $finish;
  end

  initial begin
    req_valid_i = 1'b0;
    req_addr_i = '0;
    refill_valid_i = 1'b0;
    refill_line_i = '0;
    for (int s = 0; s < SETS; s++) begin
      m_vld[0][s] = 1'b0; m_vld[1][s] = 1'b0;
      m_tag[0][s] = '0;   m_tag[1][s] = '0;
      m_pred[s] = 1'b0;   m_lru[s] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    chk(req_ready_o == 1'b1, "R1 ready after reset", 64'(req_ready_o), 1);
    chk(resp_valid_o == 1'b0, "R1 no response after reset", 64'(resp_valid_o), 0);
    chk(stat_access_o == 0 && stat_fast_o == 0 && stat_slow_o == 0 && stat_miss_o == 0,
        "R1 counters zero", 64'(stat_access_o), 0);

    // cold lines, fills land in way 0 then way 1
    access(mk(19'd1, 7'd5, 4'd0),  "R1 R11 cold miss");
    access(mk(19'd1, 7'd5, 4'd3),  "R8 word 3");
    access(mk(19'd1, 7'd5, 4'd15), "R8 word 15");
    access(mk(19'd1, 7'd5, 4'd7),  "R3 repeat hit");
    access(mk(19'd2, 7'd5, 4'd1),  "R7 R11 second line");
    access(mk(19'd1, 7'd5, 4'd2),  "R11 first line needs second probe");
    access(mk(19'd1, 7'd5, 4'd2),  "R5 corrected guess");
    access(mk(19'd2, 7'd5, 4'd4),  "R4 other line");
    access(mk(19'd2, 7'd5, 4'd9),  "R5 other line corrected");
    // third tag replaces the least recently used line
    access(mk(19'd3, 7'd5, 4'd0),  "R7 third tag");
    access(mk(19'd2, 7'd5, 4'd6),  "R7 recent line kept");
    access(mk(19'd1, 7'd5, 4'd0),  "R7 evicted line misses");
    access(mk(19'd3, 7'd5, 4'd8),  "R7 after second eviction");

    // stray refill while idle
    @(negedge clk);
    refill_valid_i = 1'b1;
    refill_line_i  = line_of(mk(19'd9, 7'd20, 4'd0));
    @(negedge clk);
    refill_valid_i = 1'b0;
    chk(req_ready_o == 1'b1, "R10 stray refill keeps unit idle", 64'(req_ready_o), 1);
    @(negedge clk);
    chk(resp_valid_o == 1'b0, "R10 stray refill gives no response", 64'(resp_valid_o), 0);
    access(mk(19'd9, 7'd20, 4'd0), "R10 stray refill not written");
    access(mk(19'd9, 7'd20, 4'd5), "R10 line after real refill");

    // address extremes
    access(mk(19'h7FFFF, 7'd127, 4'd15), "R8 top set top word");
    access(mk(19'h7FFFF, 7'd127, 4'd15), "R8 top set repeat");
    access(mk(19'd0, 7'd0, 4'd0),        "R8 bottom set");
    access(mk(19'd0, 7'd0, 4'd1),        "R8 bottom set repeat");

    // mixed sweep over a few sets and tags
    for (int i = 0; i < 40; i++)
      access(mk(19'(i % 3 + 4), 7'(i % 4 + 40), 4'(i % 16)), "R3 R4 R6 R7 sweep");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(stat_access_o == n_acc, "R9 access count", 64'(stat_access_o), 64'(n_acc));
    chk(stat_fast_o == n_fast,  "R9 first-probe count", 64'(stat_fast_o), 64'(n_fast));
    chk(stat_slow_o == n_slow,  "R9 second-probe count", 64'(stat_slow_o), 64'(n_slow));
    chk(stat_miss_o == n_miss,  "R9 miss count", 64'(stat_miss_o), 64'(n_miss));

    summary();
    $finish;
  end
endmodule